// File: doc/BRIEF.md
# Vector Lane Insert and Copy Unit

This execution unit moves data between a 32-bit scalar and a single lane of a 128-bit vector. It can write a scalar into one lane of a destination vector and keep every other lane as it was. It can read one lane of a source vector out as a scalar, with either sign extension or zero extension. It can also broadcast the scalar into every lane. The lane width is chosen per request: byte, halfword or word. The register file and the instruction decoder sit outside the unit. They supply the current source and destination vector contents, and they take back either a vector result or a scalar result, each with its own write enable.

Requests enter over a valid/ready handshake, and results leave over a second one. A single result register sits between the two. A request is taken in any cycle where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` in the next cycle. `in_ready` falls only while a result is waiting and the consumer holds `out_ready` low. During that stall the result stays frozen. Once `out_ready` rises, the waiting result leaves and a new request can be taken in the same cycle. A request that names a lane past the end of the chosen format, or that uses the doubleword format, returns an error flag and writes nothing.

Top module: `vec_lane_xfer`

## Requirements
- R1: Operation codes on `in_op` are: 0 insert, 1 signed copy, 2 unsigned copy, 3 fill. Format codes on `in_fmt` are: 0 byte (16 lanes), 1 halfword (8 lanes), 2 word (4 lanes), 3 doubleword. A lane of width W numbered i occupies bits [i*W +: W], so lane 0 sits at the least significant end.
- R2: Insert returns `in_dst_vec` with lane `in_lane` replaced by the low W bits of `in_scalar`, all other lanes unchanged. It sets `out_vec_we`=1, `out_scalar_we`=0 and `out_scalar`=0.
- R3: Signed copy in byte or halfword format returns lane `in_lane` of `in_src_vec` sign-extended to 32 bits. It sets `out_scalar_we`=1, `out_vec_we`=0 and `out_vec`=0.
- R4: Unsigned copy in byte or halfword format returns the lane zero-extended to 32 bits, with the same write enables as R3.
- R5: Copy in word format returns the 32-bit lane unchanged, whether signed or unsigned.
- R6: Fill writes the low W bits of `in_scalar` into every lane, with `out_vec_we`=1. For fill, `in_lane` is ignored, and no lane index ever causes an error.
- R7: The doubleword format with any operation, or a lane index at or above the lane count of the format for insert or copy, gives `out_err`=1. Both write enables are then 0, and `out_vec` and `out_scalar` are 0.
- R8: A request is accepted when `in_valid` and `in_ready` are both high, and its result shows with `out_valid`=1 in the next cycle. A result handed off while a new request is accepted is replaced by the new result with no gap.
- R9: While `out_valid`=1 and `out_ready`=0, every output holds its value and `in_ready` is 0.
- R10: While reset is held and after its release, `out_valid`=0 and `in_ready`=1.
- R11: When `out_valid`=0, `out_vec_we`, `out_scalar_we` and `out_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 2 | Operation code (R1) |
| in_fmt | input | 2 | Lane format code (R1) |
| in_lane | input | 4 | Lane index |
| in_scalar | input | 32 | Scalar operand |
| in_src_vec | input | 128 | Vector read by copy |
| in_dst_vec | input | 128 | Current destination vector, merged by insert |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 128 | Vector result |
| out_vec_we | output | 1 | Write the vector result |
| out_scalar | output | 32 | Scalar result |
| out_scalar_we | output | 1 | Write the scalar result |
| out_err | output | 1 | Request was illegal, nothing written |

## Verification
Two things can happen in the same cycle: the current result is handed off, and the next request is captured. The bench sets this up in two ways. First it streams requests back to back with `out_ready` held high. Then it stalls a result with `out_ready` low while a second request waits, and releases the stall. It passes if each new result follows its predecessor with no lost or repeated result, and if every output stays unchanged for as long as the stall lasts.

// File: rtl/vlx_pkg.sv
package vlx_pkg;
  typedef enum logic [1:0] {
    OP_INS  = 2'd0,
    OP_CPS  = 2'd1,
    OP_CPU  = 2'd2,
    OP_FILL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FMT_B = 2'd0,
    FMT_H = 2'd1,
    FMT_W = 2'd2,
    FMT_D = 2'd3
  } fmt_e;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
endpackage

// File: rtl/vlx_extract.sv
module vlx_extract #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = $clog2(VEC_W / vlx_pkg::BYTE_W)
) (
  input  logic [VEC_W-1:0] src,
  input  vlx_pkg::fmt_e    fmt,
  input  logic [IDX_W-1:0] lane,
  input  logic             sext,
  output logic [SCL_W-1:0] val
);
  import vlx_pkg::*;

  localparam int NB = VEC_W / BYTE_W;
  localparam int NH = VEC_W / HALF_W;
  localparam int NW = VEC_W / SCL_W;
  localparam int HI = $clog2(NH);
  localparam int WI = $clog2(NW);

  logic [BYTE_W-1:0] b_ln [NB];
  logic [HALF_W-1:0] h_ln [NH];
  logic [SCL_W-1:0]  w_ln [NW];

  for (genvar i = 0; i < NB; i++) begin : g_b
    assign b_ln[i] = src[i*BYTE_W +: BYTE_W];
  end
  for (genvar i = 0; i < NH; i++) begin : g_h
    assign h_ln[i] = src[i*HALF_W +: HALF_W];
  end
  for (genvar i = 0; i < NW; i++) begin : g_w
    assign w_ln[i] = src[i*SCL_W +: SCL_W];
  end

  logic [BYTE_W-1:0] bsel;
  logic [HALF_W-1:0] hsel;
  logic [SCL_W-1:0]  wsel;

  always_comb begin
    bsel = b_ln[lane];
    hsel = h_ln[lane[HI-1:0]];
    wsel = w_ln[lane[WI-1:0]];
    case (fmt)
      FMT_B:   val = {{(SCL_W-BYTE_W){sext & bsel[BYTE_W-1]}}, bsel};
      FMT_H:   val = {{(SCL_W-HALF_W){sext & hsel[HALF_W-1]}}, hsel};
      default: val = wsel;
    endcase
  end
endmodule

// File: rtl/vlx_insert.sv
module vlx_insert #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = $clog2(VEC_W / vlx_pkg::BYTE_W)
) (
  input  logic [VEC_W-1:0] dst,
  input  vlx_pkg::fmt_e    fmt,
  input  logic [IDX_W-1:0] lane,
  input  logic             fill,
  input  logic [SCL_W-1:0] scalar,
  output logic [VEC_W-1:0] res
);
  import vlx_pkg::*;

  localparam int NB = VEC_W / BYTE_W;
  localparam int NH = VEC_W / HALF_W;
  localparam int NW = VEC_W / SCL_W;

  logic [VEC_W-1:0] b_res, h_res, w_res;

  for (genvar i = 0; i < NB; i++) begin : g_b
    assign b_res[i*BYTE_W +: BYTE_W] = (fill || lane == IDX_W'(i)) ?
                                       scalar[BYTE_W-1:0] : dst[i*BYTE_W +: BYTE_W];
  end
  for (genvar i = 0; i < NH; i++) begin : g_h
    assign h_res[i*HALF_W +: HALF_W] = (fill || lane == IDX_W'(i)) ?
                                       scalar[HALF_W-1:0] : dst[i*HALF_W +: HALF_W];
  end
  for (genvar i = 0; i < NW; i++) begin : g_w
    assign w_res[i*SCL_W +: SCL_W] = (fill || lane == IDX_W'(i)) ?
                                     scalar : dst[i*SCL_W +: SCL_W];
  end

  always_comb begin
    case (fmt)
      FMT_B:   res = b_res;
      FMT_H:   res = h_res;
      FMT_W:   res = w_res;
      default: res = dst;
    endcase
  end
endmodule

// File: rtl/vlx_stage.sv
module vlx_stage #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] d_vec,
  input  logic             d_vwe,
  input  logic [SCL_W-1:0] d_scl,
  input  logic             d_swe,
  input  logic             d_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] q_vec,
  output logic             q_vwe,
  output logic [SCL_W-1:0] q_scl,
  output logic             q_swe,
  output logic             q_err
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_vec     <= '0;
      q_vwe     <= 1'b0;
      q_scl     <= '0;
      q_swe     <= 1'b0;
      q_err     <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      q_vec     <= in_valid ? d_vec : '0;
      q_vwe     <= in_valid & d_vwe;
      q_scl     <= in_valid ? d_scl : '0;
      q_swe     <= in_valid & d_swe;
      q_err     <= in_valid & d_err;
    end
  end
endmodule

// File: rtl/vec_lane_xfer.sv
module vec_lane_xfer #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = $clog2(VEC_W / vlx_pkg::BYTE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [1:0]       in_fmt,
  input  logic [IDX_W-1:0] in_lane,
  input  logic [SCL_W-1:0] in_scalar,
  input  logic [VEC_W-1:0] in_src_vec,
  input  logic [VEC_W-1:0] in_dst_vec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_vec_we,
  output logic [SCL_W-1:0] out_scalar,
  output logic             out_scalar_we,
  output logic             out_err
);
  import vlx_pkg::*;

  localparam int LW = IDX_W + 1;
  localparam int NB = VEC_W / BYTE_W;
  localparam int NH = VEC_W / HALF_W;
  localparam int NW = VEC_W / SCL_W;

  op_e  op;
  fmt_e fmt;
  assign op  = op_e'(in_op);
  assign fmt = fmt_e'(in_fmt);

  logic [LW-1:0]    lane_ext;
  logic             oob, is_copy, err;
  logic [VEC_W-1:0] ins_vec, d_vec;
  logic [SCL_W-1:0] ext_val, d_scl;
  logic             d_vwe, d_swe;

  assign lane_ext = {1'b0, in_lane};
  assign is_copy  = (op == OP_CPS) || (op == OP_CPU);

  always_comb begin
    case (fmt)
      FMT_B:   oob = lane_ext >= LW'(NB);
      FMT_H:   oob = lane_ext >= LW'(NH);
      FMT_W:   oob = lane_ext >= LW'(NW);
      default: oob = 1'b1;
    endcase
    err   = (fmt == FMT_D) || ((op != OP_FILL) && oob);
    d_vwe = !err && !is_copy;
    d_swe = !err && is_copy;
    d_vec = d_vwe ? ins_vec : '0;
    d_scl = d_swe ? ext_val : '0;
  end

  vlx_extract #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_ext (
    .src  (in_src_vec),
    .fmt  (fmt),
    .lane (in_lane),
    .sext (op == OP_CPS),
    .val  (ext_val)
  );

  vlx_insert #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_ins (
    .dst    (in_dst_vec),
    .fmt    (fmt),
    .lane   (in_lane),
    .fill   (op == OP_FILL),
    .scalar (in_scalar),
    .res    (ins_vec)
  );

  vlx_stage #(.VEC_W(VEC_W), .SCL_W(SCL_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_vec     (d_vec),
    .d_vwe     (d_vwe),
    .d_scl     (d_scl),
    .d_swe     (d_swe),
    .d_err     (err),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_vec     (out_vec),
    .q_vwe     (out_vec_we),
    .q_scl     (out_scalar),
    .q_swe     (out_scalar_we),
    .q_err     (out_err)
  );
endmodule

// File: rtl/vlx_chk.sv
module vlx_chk #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic             out_vec_we,
  input logic [SCL_W-1:0] out_scalar,
  input logic             out_scalar_we,
  input logic             out_err
);
  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_scalar)
      && $stable(out_vec_we) && $stable(out_scalar_we) && $stable(out_err));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> !out_vec_we && !out_scalar_we);

  // R2
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vec_we && out_scalar_we));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_vec_we && !out_scalar_we && !out_err);
endmodule

bind vec_lane_xfer vlx_chk #(.VEC_W(VEC_W), .SCL_W(SCL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_vec       (out_vec),
  .out_vec_we    (out_vec_we),
  .out_scalar    (out_scalar),
  .out_scalar_we (out_scalar_we),
  .out_err       (out_err)
);

// File: tb/vec_lane_xfer_bench.sv
module vec_lane_xfer_bench;
  localparam logic [127:0] SRC = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
  localparam logic [127:0] DST = 128'h01234567_89ABCDEF_FEDCBA98_76543210;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  fmt;
    logic [3:0]  lane;
    logic [31:0] scl;
    logic [31:0] exp_scl;
    logic        exp_err;
  } vec_t;

  localparam int NV = 24;
  // op: 0 ins 1 cps 2 cpu 3 fill; fmt: 0 b 1 h 2 w 3 d (R1)
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd0, 4'd15, 32'h0, 32'hFFFFFFF0, 1'b0},
    '{2'd2, 2'd0, 4'd15, 32'h0, 32'h000000F0, 1'b0},
    '{2'd1, 2'd0, 4'd1,  32'h0, 32'h0000001E, 1'b0},
    '{2'd1, 2'd0, 4'd8,  32'h0, 32'hFFFFFF87, 1'b0},
    '{2'd1, 2'd1, 4'd4,  32'h0, 32'hFFFF9687, 1'b0},
    '{2'd2, 2'd1, 4'd4,  32'h0, 32'h00009687, 1'b0},
    '{2'd1, 2'd1, 4'd0,  32'h0, 32'h00001E0F, 1'b0},
    '{2'd2, 2'd1, 4'd7,  32'h0, 32'h0000F0E1, 1'b0},
    '{2'd1, 2'd2, 4'd3,  32'h0, 32'hF0E1D2C3, 1'b0},
    '{2'd2, 2'd2, 4'd3,  32'h0, 32'hF0E1D2C3, 1'b0},
    '{2'd2, 2'd2, 4'd0,  32'h0, 32'h3C2D1E0F, 1'b0},
    '{2'd0, 2'd0, 4'd0,  32'h12345678, 32'h0, 1'b0},
    '{2'd0, 2'd0, 4'd15, 32'h9ABCDEF0, 32'h0, 1'b0},
    '{2'd0, 2'd1, 4'd7,  32'h12345678, 32'h0, 1'b0},
    '{2'd0, 2'd1, 4'd3,  32'h0000BEEF, 32'h0, 1'b0},
    '{2'd0, 2'd2, 4'd2,  32'hCAFEF00D, 32'h0, 1'b0},
    '{2'd3, 2'd0, 4'd9,  32'hAABBCCDD, 32'h0, 1'b0},
    '{2'd3, 2'd1, 4'd15, 32'hAABBCCDD, 32'h0, 1'b0},
    '{2'd3, 2'd2, 4'd0,  32'h11223344, 32'h0, 1'b0},
    '{2'd1, 2'd1, 4'd8,  32'h0, 32'h0, 1'b1},
    '{2'd2, 2'd2, 4'd4,  32'h0, 32'h0, 1'b1},
    '{2'd0, 2'd3, 4'd0,  32'h5A, 32'h0, 1'b1},
    '{2'd3, 2'd3, 4'd0,  32'h5A, 32'h0, 1'b1},
    '{2'd0, 2'd2, 4'd15, 32'h5A, 32'h0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = '0;
  logic [1:0]   in_fmt = '0;
  logic [3:0]   in_lane = '0;
  logic [31:0]  in_scalar = '0;
  logic [127:0] in_src_vec = SRC;
  logic [127:0] in_dst_vec = DST;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;
  logic         out_vec_we;
  logic [31:0]  out_scalar;
  logic         out_scalar_we;
  logic         out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_lane_xfer u_vec_lane_xfer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fmt(in_fmt), .in_lane(in_lane), .in_scalar(in_scalar),
    .in_src_vec(in_src_vec), .in_dst_vec(in_dst_vec), .out_valid(out_valid),
    .out_ready(out_ready), .out_vec(out_vec), .out_vec_we(out_vec_we),
    .out_scalar(out_scalar), .out_scalar_we(out_scalar_we), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_vec(input vec_t e);
    logic [127:0] r;
    int w;
    r = DST;
    if (e.exp_err || e.op == 2'd1 || e.op == 2'd2) return '0;
    w = 8 << e.fmt;
    for (int b = 0; b < 128; b++) begin
      if (e.op == 2'd3 || (b / w) == int'(e.lane)) r[b] = e.scl[b % w];
    end
    return r;
  endfunction

  function automatic string tag_of(input vec_t e);
    if (e.exp_err) return "R7";
    if (e.op == 2'd3) return "R6";
    if (e.op == 2'd0) return "R2 R1";
    if (e.fmt == 2'd2) return "R5";
    if (e.op == 2'd1) return "R3 R1";
    return "R4";
  endfunction

  task automatic drive(input vec_t e);
    in_op = e.op; in_fmt = e.fmt; in_lane = e.lane; in_scalar = e.scl;
    in_valid = 1'b1;
  endtask

  task automatic check_out(input vec_t e);
    string t;
    bit cp;
    t  = tag_of(e);
    cp = (e.op == 2'd1 || e.op == 2'd2);
    chk(out_valid === 1'b1, {t, " R8 valid"}, 128'(out_valid), 128'd1);
    chk(out_err === e.exp_err, {t, " err"}, 128'(out_err), 128'(e.exp_err));
    chk(out_vec_we === (!e.exp_err && !cp), {t, " vec_we"}, 128'(out_vec_we),
        128'(!e.exp_err && !cp));
    chk(out_scalar_we === (!e.exp_err && cp), {t, " scalar_we"}, 128'(out_scalar_we),
        128'(!e.exp_err && cp));
    chk(out_scalar === e.exp_scl, {t, " scalar"}, 128'(out_scalar), 128'(e.exp_scl));
    chk(out_vec === model_vec(e), {t, " vec"}, out_vec, model_vec(e));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t a, b, c;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid === 1'b0, "R10 out_valid in reset", 128'(out_valid), 128'd0);
    chk(in_ready === 1'b1, "R10 in_ready in reset", 128'(in_ready), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 out_valid after reset", 128'(out_valid), 128'd0);
    chk({out_vec_we, out_scalar_we, out_err} === 3'b000, "R11 idle enables",
        128'({out_vec_we, out_scalar_we, out_err}), 128'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check_out(TBL[i]);
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 drained", 128'(out_valid), 128'd0);

    // R9 stall then R8 handoff with simultaneous accept
    a = TBL[0];
    b = TBL[5];
    out_ready = 1'b0;
    drive(a);
    @(negedge clk);
    check_out(a);
    chk(in_ready === 1'b0, "R9 ready low in stall", 128'(in_ready), 128'd0);
    drive(b);
    repeat (2) begin
      @(negedge clk);
      chk(out_scalar === a.exp_scl && out_valid === 1'b1, "R9 held result",
          128'(out_scalar), 128'(a.exp_scl));
      chk(in_ready === 1'b0, "R9 ready held low", 128'(in_ready), 128'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(b);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 single result after stall", 128'(out_valid), 128'd0);

    // R8 back-to-back stream
    a = '{2'd0, 2'd2, 4'd0, 32'hDEADBEEF, 32'h0, 1'b0};
    b = '{2'd1, 2'd0, 4'd2, 32'h0, 32'h0000002D, 1'b0};
    c = '{2'd3, 2'd0, 4'd3, 32'h00000055, 32'h0, 1'b0};
    drive(a);
    @(negedge clk);
    check_out(a);
    drive(b);
    @(negedge clk);
    check_out(b);
    drive(c);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(c);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 stream end", 128'(out_valid), 128'd0);

    // R10: reset while a result waits
    out_ready = 1'b0;
    drive(TBL[1]);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 reset clears result", 128'(out_valid), 128'd0);
    chk(in_ready === 1'b1, "R10 reset ready", 128'(in_ready), 128'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule